// File: doc/BRIEF.md
# Host Command Register Handler

This block sits between a host register port and the card's timing logic. It holds a small bank of 16-bit registers and runs a two-state command engine. To issue a command, the host fills two command halves that together form one 32-bit word. It then sets the pending flag in the status register. The engine sees the flag, decodes and executes the word in one cycle, and drops the flag in the following cycle. Polling the flag therefore tells the host when the next command may be issued.

The block also serves two other inputs. A pulse from the interrupt generator latches a source bit that the interrupt service routine uses to confirm the card raised the line; the host clears it with write-one-to-clear. A once-per-second strobe captures a 32-bit time value into two 16-bit halves in a single cycle. Read commands copy their result into a 32-bit response pair, so a time value fetched by command always comes from one snapshot.

The host side has two streams. The write stream (wr_valid/wr_ready) and the read-request stream (rd_req_valid/rd_req_ready) never apply back-pressure: both ready outputs are held high, and every valid beat is taken on the clock edge where it is high. A read response appears with rd_valid exactly one cycle after its request. The response has no ready input, so the host must take it in that cycle. The enable and divider outputs are plain level signals.

Top module: `hostcmd_ctrl`

## Requirements
- R1: After reset, irq_enable is 0, divider equals DIV_RESET (default 0x03E8), and the status, mask, command, time and response registers read 0.
- R2: The register addresses are: 0 command low (operand), 1 command high (opcode in bits 15:8, reserved bits 7:0), 2 status, 3 divider, 4 mask, 5 time low, 6 time high, 7 response low, 8 response high. Any other address reads 0. A read request returns rd_valid=1 one cycle later, with the addressed value as it stood in the request cycle. When no request is made, rd_valid=0 and rd_data=0.
- R3: Status bit 2 is the pending flag. Writing status with bit 2 = 1 sets it, and writing 0 there has no effect. Once set, the flag reads 1 for exactly two cycles (execute, then end) and is then cleared by the engine.
- R4: The command word is {command high, command low}. Opcode 0x01 sets irq_enable and opcode 0x02 clears it. Both act in the execute cycle.
- R5: Opcode 0x05 loads the divider from the operand. A host write to address 3 also loads it. When both happen in the same cycle, the command wins.
- R6: Opcode 0x03 loads response low with the status value seen in the execute cycle (flag bit set) and response high with 0. Opcode 0x04 loads response low with the divider and response high with 0. Opcode 0x06 loads response high/low with the captured time high/low.
- R7: An opcode outside 0x01..0x06, or nonzero reserved bits, sets status bit 3 (error) and changes nothing else. Any accepted command clears bit 3.
- R8: While the pending flag is 1, host writes to both command halves are ignored.
- R9: Mask bit 1 is set by an irq_event pulse and cleared by a host write of 1 to that bit. An event in the same cycle as the clear leaves it set. Other mask bits read 0.
- R10: When pps_tick is high, gps_time[31:16] and gps_time[15:0] are captured into time high and time low on the same edge.
- R11: Status bit 0 reads the current irq_enable. Status bits 1 and 15:4 read 0, and host writes to status bits other than bit 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Write stream ready, always 1 |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 16 | Write data |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request ready, always 1 |
| rd_addr | input | 4 | Read register address |
| rd_valid | output | 1 | Read response valid, one cycle after request |
| rd_data | output | 16 | Read response data |
| irq_event | input | 1 | Interrupt line asserted by the generator |
| pps_tick | input | 1 | Once-per-second capture strobe |
| gps_time | input | 32 | Current time value |
| irq_enable | output | 1 | Interrupt generation enable |
| divider | output | 16 | Interrupt divider value |

## Verification
The assertions assume that every input is synchronous to clk and known after reset. They also assume that a command word is only ever changed by the host port. The flag-lifetime property assumes the host cannot set the flag again in the cycle the engine clears it, which holds because the flag is still high during the end cycle. The stimulus changes inputs only in the middle of a cycle. It issues commands only through the normal sequence of writing both halves and then the flag, and it includes deliberate writes to the command halves while a command is pending. It also pulses irq_event and pps_tick in the same cycle as host writes to the registers they touch.

// File: rtl/hc_pkg.sv
package hc_pkg;

  localparam int DW      = 16;
  localparam int AW      = 4;
  localparam int CW      = 2 * DW;
  localparam int OPW     = 8;
  localparam int TW      = 2 * DW;
  localparam int NHALF   = CW / DW;

  localparam logic [AW-1:0] A_CMD_LO  = 4'd0;
  localparam logic [AW-1:0] A_CMD_HI  = 4'd1;
  localparam logic [AW-1:0] A_STATUS  = 4'd2;
  localparam logic [AW-1:0] A_DIV     = 4'd3;
  localparam logic [AW-1:0] A_MASK    = 4'd4;
  localparam logic [AW-1:0] A_TIME_LO = 4'd5;
  localparam logic [AW-1:0] A_TIME_HI = 4'd6;
  localparam logic [AW-1:0] A_RSP_LO  = 4'd7;
  localparam logic [AW-1:0] A_RSP_HI  = 4'd8;

  localparam int ST_EN   = 0;
  localparam int ST_FLAG = 2;
  localparam int ST_ERR  = 3;
  localparam int MK_SRC  = 1;

  localparam logic [OPW-1:0] OP_EN     = 8'h01;
  localparam logic [OPW-1:0] OP_DIS    = 8'h02;
  localparam logic [OPW-1:0] OP_RD_ST  = 8'h03;
  localparam logic [OPW-1:0] OP_RD_DIV = 8'h04;
  localparam logic [OPW-1:0] OP_SET_DV = 8'h05;
  localparam logic [OPW-1:0] OP_RD_TM  = 8'h06;

  typedef enum logic {S_IDLE, S_END} eng_state_e;

  typedef struct packed {
    logic          set_en;
    logic          clr_en;
    logic          ld_div;
    logic [DW-1:0] div_val;
    logic          ld_rsp;
    logic [DW-1:0] rsp_hi;
    logic [DW-1:0] rsp_lo;
    logic          set_err;
    logic          clr_err;
  } act_t;

  function automatic logic word_ok(input logic [CW-1:0] w);
    logic [OPW-1:0] op;
    op = w[CW-1 -: OPW];
    return (w[CW-OPW-1 -: OPW] == '0) && (op >= OP_EN) && (op <= OP_RD_TM);
  endfunction

endpackage

// File: rtl/hc_time_snap.sv
module hc_time_snap
  import hc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps_tick,
  input  logic [TW-1:0] gps_time,
  output logic [DW-1:0] snap_hi,
  output logic [DW-1:0] snap_lo
);

  logic [TW-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (pps_tick) begin
      snap_q <= gps_time;
    end
  end

  assign snap_hi = snap_q[TW-1 -: DW];
  assign snap_lo = snap_q[DW-1:0];

endmodule

// File: rtl/hc_cmd_fsm.sv
module hc_cmd_fsm
  import hc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_flag,
  input  logic [CW-1:0] cmd_word,
  input  logic [DW-1:0] status_q,
  input  logic [DW-1:0] div_q,
  input  logic [DW-1:0] snap_hi,
  input  logic [DW-1:0] snap_lo,
  output act_t          act,
  output logic          exec,
  output logic          flag_clr,
  output eng_state_e    state_o
);

  eng_state_e     state_q, state_d;
  logic [OPW-1:0] opcode;
  logic [DW-1:0]  operand;

  assign opcode  = cmd_word[CW-1 -: OPW];
  assign operand = cmd_word[DW-1:0];
  assign state_o = state_q;

  always_comb begin
    act      = '0;
    exec     = 1'b0;
    flag_clr = 1'b0;
    state_d  = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_flag) begin
          exec    = 1'b1;
          state_d = S_END;
          if (!word_ok(cmd_word)) begin
            act.set_err = 1'b1;
          end else begin
            act.clr_err = 1'b1;
            case (opcode)
              OP_EN:     act.set_en = 1'b1;
              OP_DIS:    act.clr_en = 1'b1;
              OP_RD_ST: begin
                act.ld_rsp = 1'b1;
                act.rsp_lo = status_q;
              end
              OP_RD_DIV: begin
                act.ld_rsp = 1'b1;
                act.rsp_lo = div_q;
              end
              OP_SET_DV: begin
                act.ld_div  = 1'b1;
                act.div_val = operand;
              end
              OP_RD_TM: begin
                act.ld_rsp = 1'b1;
                act.rsp_hi = snap_hi;
                act.rsp_lo = snap_lo;
              end
              default: act.set_err = 1'b1;
            endcase
          end
        end
      end
      S_END: begin
        flag_clr = 1'b1;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/hc_regbank.sv
module hc_regbank
  import hc_pkg::*;
#(
  parameter logic [DW-1:0] DIV_RESET = 16'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_fire,
  input  logic [AW-1:0] rd_addr,
  input  logic          irq_event,
  input  act_t          act,
  input  logic          flag_clr,
  input  logic [DW-1:0] snap_hi,
  input  logic [DW-1:0] snap_lo,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] status_q,
  output logic [CW-1:0] cmd_word,
  output logic [DW-1:0] div_q,
  output logic          en_q,
  output logic          flag_q,
  output logic          src_q
);

  logic          err_q;
  logic [DW-1:0] rsp_hi_q, rsp_lo_q;
  logic [DW-1:0] mask_rd;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] cmd_half [NHALF];

  always_comb begin
    status_q          = '0;
    status_q[ST_EN]   = en_q;
    status_q[ST_FLAG] = flag_q;
    status_q[ST_ERR]  = err_q;
    mask_rd           = '0;
    mask_rd[MK_SRC]   = src_q;
  end

  for (genvar g = 0; g < NHALF; g++) begin : g_cmd
    logic hit;
    assign hit = wr_fire && (wr_addr == A_CMD_LO + AW'(g)) && !flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)   cmd_half[g] <= '0;
      else if (hit) cmd_half[g] <= wr_data;
    end
    assign cmd_word[g*DW +: DW] = cmd_half[g];
  end

  always_comb begin
    case (rd_addr)
      A_CMD_LO:  rd_mux = cmd_half[0];
      A_CMD_HI:  rd_mux = cmd_half[NHALF-1];
      A_STATUS:  rd_mux = status_q;
      A_DIV:     rd_mux = div_q;
      A_MASK:    rd_mux = mask_rd;
      A_TIME_LO: rd_mux = snap_lo;
      A_TIME_HI: rd_mux = snap_hi;
      A_RSP_LO:  rd_mux = rsp_lo_q;
      A_RSP_HI:  rd_mux = rsp_hi_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      flag_q   <= 1'b0;
      err_q    <= 1'b0;
      en_q     <= 1'b0;
      div_q    <= DIV_RESET;
      rsp_hi_q <= '0;
      rsp_lo_q <= '0;
      src_q    <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      rd_data  <= rd_fire ? rd_mux : '0;

      if (flag_clr)
        flag_q <= 1'b0;
      else if (wr_fire && wr_addr == A_STATUS && wr_data[ST_FLAG])
        flag_q <= 1'b1;

      if (act.set_err)      err_q <= 1'b1;
      else if (act.clr_err) err_q <= 1'b0;

      if (act.set_en)      en_q <= 1'b1;
      else if (act.clr_en) en_q <= 1'b0;

      if (act.ld_div)
        div_q <= act.div_val;
      else if (wr_fire && wr_addr == A_DIV)
        div_q <= wr_data;

      if (act.ld_rsp) begin
        rsp_hi_q <= act.rsp_hi;
        rsp_lo_q <= act.rsp_lo;
      end

      if (irq_event)
        src_q <= 1'b1;
      else if (wr_fire && wr_addr == A_MASK && wr_data[MK_SRC])
        src_q <= 1'b0;
    end
  end

endmodule

// File: rtl/hostcmd_ctrl.sv
module hostcmd_ctrl
  import hc_pkg::*;
#(
  parameter logic [DW-1:0] DIV_RESET = 16'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req_valid,
  output logic          rd_req_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          irq_event,
  input  logic          pps_tick,
  input  logic [TW-1:0] gps_time,
  output logic          irq_enable,
  output logic [DW-1:0] divider
);

  logic          cmd_flag, src_flag, exec, flag_clr;
  logic [CW-1:0] cmd_word;
  logic [DW-1:0] status_q, snap_hi, snap_lo;
  act_t          act;
  eng_state_e    eng_state;

  assign wr_ready     = 1'b1;
  assign rd_req_ready = 1'b1;

  hc_time_snap u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pps_tick (pps_tick),
    .gps_time (gps_time),
    .snap_hi  (snap_hi),
    .snap_lo  (snap_lo)
  );

  hc_cmd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_flag (cmd_flag),
    .cmd_word (cmd_word),
    .status_q (status_q),
    .div_q    (divider),
    .snap_hi  (snap_hi),
    .snap_lo  (snap_lo),
    .act      (act),
    .exec     (exec),
    .flag_clr (flag_clr),
    .state_o  (eng_state)
  );

  hc_regbank #(.DIV_RESET(DIV_RESET)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_valid && wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_fire   (rd_req_valid && rd_req_ready),
    .rd_addr   (rd_addr),
    .irq_event (irq_event),
    .act       (act),
    .flag_clr  (flag_clr),
    .snap_hi   (snap_hi),
    .snap_lo   (snap_lo),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .status_q  (status_q),
    .cmd_word  (cmd_word),
    .div_q     (divider),
    .en_q      (irq_enable),
    .flag_q    (cmd_flag),
    .src_q     (src_flag)
  );

endmodule

// File: rtl/hostcmd_ctrl_chk.sv
module hostcmd_ctrl_chk
  import hc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          rd_req_valid,
  input logic          rd_valid,
  input logic          irq_event,
  input logic          pps_tick,
  input logic [TW-1:0] gps_time,
  input logic          irq_enable,
  input logic [DW-1:0] divider,
  input logic          cmd_flag,
  input logic          src_flag,
  input logic          exec,
  input logic [CW-1:0] cmd_word,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] snap_hi,
  input logic [DW-1:0] snap_lo,
  input act_t          act
);

  assert_flag_life_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flag && $past(cmd_flag)) |=> !cmd_flag);

  assert_exec_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec |-> cmd_flag);

  assert_cmd_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flag |=> $stable(cmd_word));

  assert_src_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> src_flag);

  assert_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pps_tick |=> ({snap_hi, snap_lo} == $past(gps_time)));

  assert_rd_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |=> rd_valid);

  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_valid |=> !rd_valid);

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_valid && wr_addr == A_DIV) && !act.ld_div) |=> $stable(divider));

  assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word_ok(cmd_word) && cmd_word[CW-1 -: OPW] == OP_EN) |=> irq_enable);

  assert_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word_ok(cmd_word) && cmd_word[CW-1 -: OPW] == OP_DIS) |=> !irq_enable);

  assert_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !word_ok(cmd_word)) |=> status_q[ST_ERR]);

  assert_unknown_keeps_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !word_ok(cmd_word)) |=> $stable(irq_enable));

  always_comb begin
    if (rst_n) begin
      assert_en_onehot_R4: assert ($onehot0({act.set_en, act.clr_en}));
      assert_status_bit0_R11: assert (status_q[ST_EN] == irq_enable);
    end
  end

endmodule

bind hostcmd_ctrl hostcmd_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_addr      (wr_addr),
  .rd_req_valid (rd_req_valid),
  .rd_valid     (rd_valid),
  .irq_event    (irq_event),
  .pps_tick     (pps_tick),
  .gps_time     (gps_time),
  .irq_enable   (irq_enable),
  .divider      (divider),
  .cmd_flag     (cmd_flag),
  .src_flag     (src_flag),
  .exec         (exec),
  .cmd_word     (cmd_word),
  .status_q     (status_q),
  .snap_hi      (snap_hi),
  .snap_lo      (snap_lo),
  .act          (act)
);

// File: tb/tb_hostcmd_ctrl.sv
`timescale 1ns/1ps
module tb_hostcmd_ctrl;

  localparam logic [15:0] DIV_RST = 16'h03E8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_req_valid = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic        irq_event = 1'b0, pps_tick = 1'b0;
  logic [31:0] gps_time = '0;
  logic        wr_ready, rd_req_ready, rd_valid, irq_enable;
  logic [15:0] rd_data, divider;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hostcmd_ctrl #(.DIV_RESET(DIV_RST)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_event(irq_event), .pps_tick(pps_tick), .gps_time(gps_time),
    .irq_enable(irq_enable), .divider(divider)
  );

  // behavioural model state
  logic        m_en, m_flag, m_err, m_src, m_end, m_rdv;
  logic [15:0] m_div, m_lo, m_hi, m_rlo, m_rhi, m_tlo, m_thi, m_rdd;

  function automatic logic [15:0] m_status();
    return {12'h000, m_err, m_flag, 1'b0, m_en};
  endfunction

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_lo;
      4'd1: return m_hi;
      4'd2: return m_status();
      4'd3: return m_div;
      4'd4: return {14'h0, m_src, 1'b0};
      4'd5: return m_tlo;
      4'd6: return m_thi;
      4'd7: return m_rlo;
      4'd8: return m_rhi;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_en = 0; m_flag = 0; m_err = 0; m_src = 0; m_end = 0; m_rdv = 0;
    m_div = DIV_RST; m_lo = 0; m_hi = 0; m_rlo = 0; m_rhi = 0;
    m_tlo = 0; m_thi = 0; m_rdd = 0;
  endtask

  task automatic model_step();
    logic t_en, t_flag, t_err, t_src, t_end;
    logic [15:0] t_div, t_lo, t_hi, t_rlo, t_rhi, t_tlo, t_thi;
    logic [7:0] op;
    t_en = m_en; t_flag = m_flag; t_err = m_err; t_src = m_src; t_end = m_end;
    t_div = m_div; t_lo = m_lo; t_hi = m_hi; t_rlo = m_rlo; t_rhi = m_rhi;
    t_tlo = m_tlo; t_thi = m_thi;
    if (wr_valid) begin
      case (wr_addr)
        4'd0: if (!m_flag) t_lo = wr_data;
        4'd1: if (!m_flag) t_hi = wr_data;
        4'd2: if (wr_data[2]) t_flag = 1;
        4'd3: t_div = wr_data;
        4'd4: if (wr_data[1]) t_src = 0;
        default: ;
      endcase
    end
    if (irq_event) t_src = 1;
    if (pps_tick) begin t_thi = gps_time[31:16]; t_tlo = gps_time[15:0]; end
    if (!m_end && m_flag) begin
      t_end = 1;
      op = m_hi[15:8];
      if (m_hi[7:0] != 0 || op < 8'h01 || op > 8'h06) t_err = 1;
      else begin
        t_err = 0;
        case (op)
          8'h01: t_en = 1;
          8'h02: t_en = 0;
          8'h03: begin t_rhi = 0; t_rlo = m_status(); end
          8'h04: begin t_rhi = 0; t_rlo = m_div; end
          8'h05: t_div = m_lo;
          default: begin t_rhi = m_thi; t_rlo = m_tlo; end
        endcase
      end
    end else if (m_end) begin
      t_flag = 0; t_end = 0;
    end
    m_rdv = rd_req_valid;
    m_rdd = rd_req_valid ? m_read(rd_addr) : 16'h0;
    m_en = t_en; m_flag = t_flag; m_err = t_err; m_src = t_src; m_end = t_end;
    m_div = t_div; m_lo = t_lo; m_hi = t_hi; m_rlo = t_rlo; m_rhi = t_rhi;
    m_tlo = t_tlo; m_thi = t_thi;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 rd_valid vs model", {31'b0, rd_valid}, {31'b0, m_rdv});
    chk("R2 rd_data vs model", {16'b0, rd_data}, {16'b0, m_rdd});
    chk("R4 irq_enable vs model", {31'b0, irq_enable}, {31'b0, m_en});
    chk("R5 divider vs model", {16'b0, divider}, {16'b0, m_div});
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    #1;
    compare_all();
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [15:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    tick();
    wr_valid = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    rd_req_valid = 1; rd_addr = a;
    tick();
    rd_req_valid = 0;
    chk(tag, {16'b0, rd_data}, {16'b0, exp});
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [15:0] operand);
    host_wr(4'd0, operand);
    host_wr(4'd1, {op, 8'h00});
    host_wr(4'd2, 16'h0004);
    tick();
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) tick();
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 divider reset", {16'b0, divider}, {16'b0, DIV_RST});
    chk("R1 enable reset", {31'b0, irq_enable}, 32'h0);
    rd_chk("R1 status reset", 4'd2, 16'h0000);
    rd_chk("R1 response reset", 4'd7, 16'h0000);
    rd_chk("R2 unmapped address", 4'hF, 16'h0000);

    // R4 / R11 enable
    send_cmd(8'h01, 16'h0000);
    chk("R4 enable command", {31'b0, irq_enable}, 32'h1);
    rd_chk("R11 status bit0 follows enable", 4'd2, 16'h0001);

    // R5 / R6 divider
    send_cmd(8'h05, 16'h1234);
    chk("R5 set divider command", {16'b0, divider}, 32'h1234);
    send_cmd(8'h04, 16'h0000);
    rd_chk("R6 divider response", 4'd7, 16'h1234);
    host_wr(4'd3, 16'h0042);
    chk("R5 host divider write", {16'b0, divider}, 32'h0042);

    // R11 write to status other bits ignored
    host_wr(4'd2, 16'hFFFB);
    rd_chk("R11 status other bits ignored", 4'd2, 16'h0001);

    // R7 unknown opcode
    send_cmd(8'h7F, 16'h5555);
    rd_chk("R7 error bit set", 4'd2, 16'h0009);
    chk("R7 divider untouched", {16'b0, divider}, 32'h0042);
    send_cmd(8'h03, 16'h0000);
    rd_chk("R6 status response", 4'd7, 16'h000D);
    rd_chk("R7 error cleared by good command", 4'd2, 16'h0001);
    host_wr(4'd0, 16'h0000);
    host_wr(4'd1, 16'h0101);
    host_wr(4'd2, 16'h0004);
    tick(); tick();
    rd_chk("R7 reserved bits rejected", 4'd2, 16'h0009);

    // R10 time capture and R6 time read
    gps_time = 32'hDEADBEEF; pps_tick = 1;
    tick();
    pps_tick = 0; gps_time = 32'h01234567;
    rd_chk("R10 time high", 4'd6, 16'hDEAD);
    rd_chk("R10 time low", 4'd5, 16'hBEEF);
    send_cmd(8'h06, 16'h0000);
    rd_chk("R6 time response high", 4'd8, 16'hDEAD);
    rd_chk("R6 time response low", 4'd7, 16'hBEEF);

    // R9 source bit
    irq_event = 1; tick(); irq_event = 0;
    rd_chk("R9 source set", 4'd4, 16'h0002);
    host_wr(4'd4, 16'h0002);
    rd_chk("R9 source cleared", 4'd4, 16'h0000);
    irq_event = 1; host_wr(4'd4, 16'h0002); irq_event = 0;
    rd_chk("R9 event beats clear", 4'd4, 16'h0002);

    // R8 command lock
    host_wr(4'd0, 16'h1111);
    host_wr(4'd1, 16'h0500);
    host_wr(4'd2, 16'h0004);
    host_wr(4'd0, 16'h2222);
    tick();
    chk("R8 locked operand used", {16'b0, divider}, 32'h1111);
    rd_chk("R8 command low kept", 4'd0, 16'h1111);

    // R3 flag lifetime, write of 0 ignored
    host_wr(4'd1, 16'h0200);
    host_wr(4'd2, 16'h0000);
    tick(); tick(); tick();
    chk("R3 zero write starts nothing", {31'b0, irq_enable}, 32'h1);
    host_wr(4'd2, 16'h0004);
    rd_chk("R3 flag high in execute cycle", 4'd2, 16'h0005);
    rd_chk("R3 flag high in end cycle", 4'd2, 16'h0004);
    rd_chk("R3 flag cleared", 4'd2, 16'h0000);
    chk("R4 disable command", {31'b0, irq_enable}, 32'h0);

    repeat (4) tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule